// File: doc/BRIEF.md
# Write-Protection Command Guard

This block sits between the bus-cycle decoder of a byte-alterable nonvolatile memory and its page-load controller. Each recognised write cycle arrives as a one-cycle strobe with its address and data. The guard watches this stream for two fixed command sequences. A three-write unlock sequence turns protection on and opens one page load. A six-write disable sequence turns protection off. A protection flag stands in for the nonvolatile enable bit. The block decides, in the cycle the strobe arrives, whether that write is forwarded to the page-load controller. Address and data go to the page-load controller directly, and only the strobe is gated.

After an unlock, any number of data writes is forwarded until the page-load controller reports that programming is complete. The guard then falls back to the protected state, and the flag stays set for the next load. In the unprotected state every write is forwarded, including command writes, which are handled like plain byte writes. The single exception is the last write of the disable sequence, which never reaches the array.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset, `prot_on_o` is 0, and every write strobe in the unprotected state appears on `wr_pass_o` in the same cycle.
- R2: The writes 0xAA to address 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, given in that order, set `prot_on_o` to 1 from the clock edge that samples the third write. This holds whether protection was set or clear before.
- R3: After an unlock, every write is forwarded until `prog_done_i` is sampled high. From then on, writes are blocked again.
- R4: While protection is set and no unlock is open, no write reaches `wr_pass_o`. This includes the command writes themselves.
- R5: A write that does not match the next expected command step ends the sequence. In the protected state that write is dropped, and a later data write stays blocked.
- R6: Successive command strobes may be at most GAP_CYCLES clock edges apart. A strobe that arrives one edge later finds the sequence aborted.
- R7: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and 0x20 to 0x5555, given in that order, clear `prot_on_o` exactly CLR_CYCLES edges after the sixth write. The sixth write and any write during that wait are never forwarded.
- R8: In the unprotected state, command writes are forwarded like data writes, except for the sixth write of the disable sequence.
- R9: If an unlock is followed by no write within GAP_CYCLES edges, the open load is withdrawn and later writes are blocked.
- R10: The flag survives the end of a page load. A second load needs a new unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb_i | input | 1 | One-cycle strobe of a recognised write cycle |
| wr_addr_i | input | ADDR_W | Address of the write |
| wr_data_i | input | DATA_W | Data of the write |
| prog_done_i | input | 1 | Pulse from the page-load controller when programming has finished |
| wr_pass_o | output | 1 | Write strobe forwarded to the page-load controller |
| prot_on_o | output | 1 | Current state of the protection flag |

## Verification
The embedded properties check several behaviours on every cycle:
- The flag can rise only on a completed unlock, and can fall only at the end of the disable wait.
- A forwarded strobe always has an input strobe behind it.
- A mismatching step returns the detector to idle.
- A finished load leaves the loading state.
- The interval counters never reach their limits.

Some behaviours can only be shown by the bench's scenarios:
- Exact window lengths on both sides of the gap limit.
- The settle delay before protection clears.
- Pass-through of command bytes in the unprotected state.
- Blocking of random traffic in the protected state.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_EXT1,
    ST_EXT2,
    ST_EXT3,
    ST_ARMED,
    ST_LOADING,
    ST_SETTLE
  } guard_state_e;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_KEY1,
    TK_KEY2,
    TK_LOCK,
    TK_EXT,
    TK_FREE
  } cmd_tok_e;

  localparam logic [7:0] KEY1_BYTE = 8'hAA;
  localparam logic [7:0] KEY2_BYTE = 8'h55;
  localparam logic [7:0] LOCK_BYTE = 8'hA0;
  localparam logic [7:0] EXT_BYTE  = 8'h80;
  localparam logic [7:0] FREE_BYTE = 8'h20;

endpackage

// File: rtl/wpd_rst_sync.sv
module wpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wpd_tok_decode.sv
module wpd_tok_decode
  import wpd_pkg::*;
#(
  parameter int              ADDR_W   = 15,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(15'h2AAA)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output cmd_tok_e          tok_o
);

  logic at_lo;
  logic at_hi;

  assign at_lo = (addr_i == LO_ADDR);
  assign at_hi = (addr_i == HI_ADDR);

  always_comb begin
    tok_o = TK_NONE;
    if (at_lo && data_i == DATA_W'(KEY1_BYTE)) begin
      tok_o = TK_KEY1;
    end else if (at_hi && data_i == DATA_W'(KEY2_BYTE)) begin
      tok_o = TK_KEY2;
    end else if (at_lo && data_i == DATA_W'(LOCK_BYTE)) begin
      tok_o = TK_LOCK;
    end else if (at_lo && data_i == DATA_W'(EXT_BYTE)) begin
      tok_o = TK_EXT;
    end else if (at_lo && data_i == DATA_W'(FREE_BYTE)) begin
      tok_o = TK_FREE;
    end
  end

endmodule

// File: rtl/wpd_interval_timer.sv
module wpd_interval_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  assign expire_o = run_i && !clear_i && (cnt_q == LAST);

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i || !run_i || expire_o) begin
      cnt_n  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_n  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

  p_expire_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wpd_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int GAP_CYCLES = 5000,
  parameter int CLR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              prog_done_i,
  output logic              wr_pass_o,
  output logic              prot_on_o
);

  logic         rst_q_n;
  cmd_tok_e     tok;
  guard_state_e state_q;
  guard_state_e state_n;
  logic         prot_q;
  logic         prot_n;
  logic         gap_run;
  logic         gap_exp;
  logic         settle_run;
  logic         settle_exp;
  logic         in_seq;

  wpd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  wpd_tok_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dec (
    .addr_i (wr_addr_i),
    .data_i (wr_data_i),
    .tok_o  (tok)
  );

  assign in_seq = (state_q == ST_KEY1) || (state_q == ST_KEY2) ||
                  (state_q == ST_EXT1) || (state_q == ST_EXT2) ||
                  (state_q == ST_EXT3);

  assign gap_run    = in_seq || (state_q == ST_ARMED);
  assign settle_run = (state_q == ST_SETTLE);

  wpd_interval_timer #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clear_i  (wr_stb_i),
    .run_i    (gap_run),
    .expire_o (gap_exp)
  );

  wpd_interval_timer #(.LIMIT(CLR_CYCLES)) u_settle (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clear_i  (!settle_run),
    .run_i    (settle_run),
    .expire_o (settle_exp)
  );

  // next-state
  always_comb begin
    state_n = state_q;
    prot_n  = prot_q;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_stb_i && tok == TK_KEY1) state_n = ST_KEY1;
      end
      ST_KEY1: begin
        if (wr_stb_i)     state_n = (tok == TK_KEY2) ? ST_KEY2 : ST_IDLE;
        else if (gap_exp) state_n = ST_IDLE;
      end
      ST_KEY2: begin
        if (wr_stb_i) begin
          if (tok == TK_LOCK) begin
            state_n = ST_ARMED;
            prot_n  = 1'b1;
          end else if (tok == TK_EXT) begin
            state_n = ST_EXT1;
          end else begin
            state_n = ST_IDLE;
          end
        end else if (gap_exp) begin
          state_n = ST_IDLE;
        end
      end
      ST_EXT1: begin
        if (wr_stb_i)     state_n = (tok == TK_KEY1) ? ST_EXT2 : ST_IDLE;
        else if (gap_exp) state_n = ST_IDLE;
      end
      ST_EXT2: begin
        if (wr_stb_i)     state_n = (tok == TK_KEY2) ? ST_EXT3 : ST_IDLE;
        else if (gap_exp) state_n = ST_IDLE;
      end
      ST_EXT3: begin
        if (wr_stb_i)     state_n = (tok == TK_FREE) ? ST_SETTLE : ST_IDLE;
        else if (gap_exp) state_n = ST_IDLE;
      end
      ST_ARMED: begin
        if (wr_stb_i)     state_n = ST_LOADING;
        else if (gap_exp) state_n = ST_IDLE;
      end
      ST_LOADING: begin
        if (prog_done_i) state_n = ST_IDLE;
      end
      ST_SETTLE: begin
        if (settle_exp) begin
          state_n = ST_IDLE;
          prot_n  = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // strobe gate
  always_comb begin
    unique case (state_q)
      ST_ARMED, ST_LOADING: wr_pass_o = wr_stb_i;
      ST_SETTLE:            wr_pass_o = 1'b0;
      ST_EXT3:              wr_pass_o = wr_stb_i && !prot_q && (tok != TK_FREE);
      default:              wr_pass_o = wr_stb_i && !prot_q;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      prot_q  <= 1'b0;
    end else begin
      if (state_n != state_q) state_q <= state_n;
      if (prot_n != prot_q)   prot_q  <= prot_n;
    end
  end

  assign prot_on_o = prot_q;

  p_pass_needs_stb_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_pass_o |-> wr_stb_i);

  p_rise_on_unlock_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(prot_q) |-> $past(state_q == ST_KEY2 && wr_stb_i && tok == TK_LOCK));

  p_fall_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(prot_q) |-> $past(state_q == ST_SETTLE));

  p_final_step_waits_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_EXT3 && wr_stb_i && tok == TK_FREE)
      |=> (state_q == ST_SETTLE && prot_q == $past(prot_q)));

  p_mismatch_idle_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_KEY1 && wr_stb_i && tok != TK_KEY2) |=> (state_q == ST_IDLE));

  p_load_ends_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_LOADING && prog_done_i) |=> (state_q == ST_IDLE));

  p_settle_blocks_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_SETTLE) |-> !wr_pass_o);

endmodule

// File: tb/wp_cmd_guard_test.sv
module wp_cmd_guard_test;

  localparam int GAP = 20;
  localparam int CLR = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        prog_done;
  logic        wr_pass;
  logic        prot_on;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wp_cmd_guard #(
    .ADDR_W     (15),
    .DATA_W     (8),
    .GAP_CYCLES (GAP),
    .CLR_CYCLES (CLR)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb_i    (wr_stb),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .prog_done_i (prog_done),
    .wr_pass_o   (wr_pass),
    .prot_on_o   (prot_on)
  );

  function automatic bit exp_plain(input bit protected_mode);
    return !protected_mode;
  endfunction

  function automatic logic [14:0] rand_addr();
    logic [14:0] a;
    a = 15'($urandom);
    if (a == 15'h5555 || a == 15'h2AAA) a = a ^ 15'h0001;
    return a;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input logic exp, input string req);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_addr = a;
    wr_data = d;
    #5;
    check(req, wr_pass, exp);
    @(posedge clk);
    #1 wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    prog_done = 1'b1;
    @(posedge clk);
    #1 prog_done = 1'b0;
  endtask

  task automatic prot_chk(input string req, input logic exp);
    @(negedge clk);
    check(req, prot_on, exp);
  endtask

  task automatic unlock(input logic exp);
    wr(15'h5555, 8'hAA, exp, "R2_key1");
    wr(15'h2AAA, 8'h55, exp, "R2_key2");
    wr(15'h5555, 8'hA0, exp, "R2_lock");
  endtask

  task automatic report();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; prog_done = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    idle(3);
    prot_chk("R1_reset", 1'b0);

    // unprotected random traffic passes
    for (int i = 0; i < 20; i++)
      wr(rand_addr(), 8'($urandom), exp_plain(1'b0), "R1_plain");

    // unlock from unprotected: commands pass as data, flag set
    unlock(1'b1);
    prot_chk("R2_set", 1'b1);
    wr(15'h0100, 8'h11, 1'b1, "R3_load0");
    wr(15'h0101, 8'h22, 1'b1, "R3_load1");
    wr(15'h0102, 8'h33, 1'b1, "R3_load2");
    done_pulse();
    wr(15'h0103, 8'h44, 1'b0, "R3_after_done");
    prot_chk("R10_persist", 1'b1);

    // protected random traffic blocked
    for (int i = 0; i < 30; i++)
      wr(rand_addr(), 8'($urandom), exp_plain(1'b1), "R4_blocked");

    // mismatch aborts
    wr(15'h5555, 8'hAA, 1'b0, "R4_cmd1");
    wr(15'h2AAA, 8'h55, 1'b0, "R4_cmd2");
    wr(15'h0100, 8'h11, 1'b0, "R5_mismatch");
    wr(15'h0101, 8'h33, 1'b0, "R5_after_abort");

    // protected unlock then a load, then need a fresh unlock
    unlock(1'b0);
    wr(15'h0200, 8'h5A, 1'b1, "R3_prot_load");
    done_pulse();
    wr(15'h0201, 8'h5B, 1'b0, "R10_second_load");

    // window edge: gap of exactly GAP edges accepted
    wr(15'h5555, 8'hAA, 1'b0, "R6_k1");
    idle(GAP - 1);
    wr(15'h2AAA, 8'h55, 1'b0, "R6_k2");
    idle(GAP - 1);
    wr(15'h5555, 8'hA0, 1'b0, "R6_lock");
    wr(15'h0300, 8'h01, 1'b1, "R6_window_ok");
    done_pulse();

    // one edge too late aborts
    wr(15'h5555, 8'hAA, 1'b0, "R6_k1_late");
    idle(GAP);
    wr(15'h2AAA, 8'h55, 1'b0, "R6_k2_late");
    wr(15'h5555, 8'hA0, 1'b0, "R6_lock_late");
    wr(15'h0301, 8'h02, 1'b0, "R6_window_expired");

    // armed but idle too long
    unlock(1'b0);
    idle(GAP);
    wr(15'h0302, 8'h03, 1'b0, "R9_armed_expired");
    prot_chk("R9_still_prot", 1'b1);

    // disable while protected
    wr(15'h5555, 8'hAA, 1'b0, "R7_d1");
    wr(15'h2AAA, 8'h55, 1'b0, "R7_d2");
    wr(15'h5555, 8'h80, 1'b0, "R7_d3");
    wr(15'h5555, 8'hAA, 1'b0, "R7_d4");
    wr(15'h2AAA, 8'h55, 1'b0, "R7_d5");
    wr(15'h5555, 8'h20, 1'b0, "R7_d6");
    idle(CLR - 1);
    #5 check("R7_not_yet", prot_on, 1'b1);
    @(posedge clk);
    #5 check("R7_cleared", prot_on, 1'b0);
    wr(15'h0400, 8'h77, 1'b1, "R1_unprot_again");

    // disable sequence while unprotected
    unlock(1'b1);
    wr(15'h0500, 8'h10, 1'b1, "R3_load");
    done_pulse();
    prot_chk("R2_set_again", 1'b1);
    wr(15'h5555, 8'hAA, 1'b0, "R7_e1");
    wr(15'h2AAA, 8'h55, 1'b0, "R7_e2");
    wr(15'h5555, 8'h80, 1'b0, "R7_e3");
    wr(15'h5555, 8'hAA, 1'b0, "R7_e4");
    wr(15'h2AAA, 8'h55, 1'b0, "R7_e5");
    wr(15'h5555, 8'h20, 1'b0, "R7_e6");
    wr(15'h0600, 8'h99, 1'b0, "R7_settle_write");
    idle(CLR);
    prot_chk("R7_clear2", 1'b0);
    wr(15'h5555, 8'hAA, 1'b1, "R8_c1");
    wr(15'h2AAA, 8'h55, 1'b1, "R8_c2");
    wr(15'h5555, 8'h80, 1'b1, "R8_c3");
    wr(15'h5555, 8'hAA, 1'b1, "R8_c4");
    wr(15'h2AAA, 8'h55, 1'b1, "R8_c5");
    wr(15'h5555, 8'h20, 1'b0, "R8_final_swallowed");
    idle(CLR + 1);
    prot_chk("R8_stays_clear", 1'b0);
    for (int i = 0; i < 10; i++)
      wr(rand_addr(), 8'($urandom), exp_plain(1'b0), "R8_plain");

    report();
  end

endmodule